// File: doc/BRIEF.md
# Rewindable Synchronous FIFO with Fall-Through Option

This block is a single-clock FIFO that can replay its contents. It has two read behaviours, and the input `fall_sel` picks one while master reset is asserted. In standard mode the consumer asks for every word with a read request, including the first one. The two flags then report empty and full. In fall-through mode the oldest word is moved onto the output by itself. The flags then report that the output holds valid data and that there is room to write. In fall-through mode the output register counts as one extra storage place.

A rewind request returns the read pointer to the first memory location. The words written since the last reset can then be read again. Rewind has a one-cycle setup phase, and the read-side flag shows it. Partial reset clears pointers, flags and output register but keeps the selected mode. A half-full flag reports when more than half of the storage is in use. All controls and flags are active low. The two resets are synchronous and active high.

Top module: `rewind_fifo`

## Requirements
- R1: On a clock edge with `mrst` high, the mode is latched from `fall_sel` (0 = standard, 1 = fall-through). No other input changes the mode, and `prst` in particular does not.
- R2: After master reset: `dout` = 0 and `half_n` = 1. In standard mode `rd_flag_n` = 0 (empty) and `wr_flag_n` = 1 (not full). In fall-through mode `rd_flag_n` = 1 (no valid output) and `wr_flag_n` = 0 (room to write).
- R3: Partial reset (`prst` high at an edge) clears the stored words, the pointers and `dout`, and sets the flags as in R2 for the mode already in force.
- R4: A write (`wr_en_n` = 0) stores `din` when the memory holds fewer than DEPTH words. Otherwise the write is dropped and stored data is unchanged. In standard mode `wr_flag_n` is 0 while DEPTH words are stored.
- R5: In standard mode a read (`rd_en_n` = 0) while the FIFO is not empty loads the oldest word into `dout` at that edge. A read while empty leaves `dout` unchanged. `rd_flag_n` is 0 while no word is stored.
- R6: In fall-through mode a word written into an empty FIFO is on `dout` with `rd_flag_n` = 0 after the second clock edge that follows its write edge, with no read request. Each read with `rd_en_n` = 0 advances `dout` to the next word. Reading the last word sets `rd_flag_n` to 1.
- R7: In fall-through mode the FIFO holds DEPTH+1 words: DEPTH in memory and one on `dout`. `wr_flag_n` is 1 while the memory holds DEPTH words.
- R8: `half_n` is 0 while the stored word count (memory plus a valid fall-through output word) exceeds DEPTH/2, and 1 otherwise.
- R9: A rewind is accepted when `rewind_n` = 0, `rd_en_n` = 1 and `wr_en_n` = 1 at an edge, and no setup is already in progress. It moves the read pointer to location 0 and starts a one-cycle setup phase. The word count becomes the number of words written since reset, which must be between 1 and DEPTH-2.
- R10: In standard mode `rd_flag_n` is 0 during rewind setup and returns to 1 at the next edge. Reads then start again from the first word written, each one needing `rd_en_n` = 0.
- R11: In fall-through mode `rd_flag_n` is 1 during rewind setup. At the next edge `rd_flag_n` goes to 0 with the first word written on `dout`, and no read is needed.
- R12: A rewind request while `rd_en_n` = 0 or `wr_en_n` = 0 is ignored. The read or write proceeds as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Master reset, synchronous, active high; latches the mode |
| prst | input | 1 | Partial reset, synchronous, active high; keeps the mode |
| fall_sel | input | 1 | Mode select sampled at master reset (1 = fall-through) |
| din | input | DW | Write data |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_n | input | 1 | Read enable, active low |
| rewind_n | input | 1 | Rewind request, active low |
| dout | output | DW | Read data register |
| rd_flag_n | output | 1 | Standard: empty (low = empty); fall-through: output ready (low = valid) |
| wr_flag_n | output | 1 | Standard: full (low = full); fall-through: input ready (low = room) |
| half_n | output | 1 | Half-full, low when more than DEPTH/2 words are stored |

## Verification
The hardest states to reach are the rewind setup cycle and the fall-through fill to DEPTH+1 words. In both, the flag polarity and the exact edge of change differ between the modes. The stimulus first drains part of the FIFO, so that the first word after a rewind can only come from location 0. It then watches the read-side flag edge by edge through the setup cycle. For the fill, writes run back to back across the two-edge fall-through latency. The write-side flag must then change exactly on the write that makes the total DEPTH+1. Rejected rewinds are issued together with a read or a write whose result would differ if the pointer had moved.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    typedef struct packed {
        logic busy;       // rewind setup cycle in progress
        logic out_valid;  // fall-through output register holds a word
        logic arm;        // fall-through fetch scheduled for next edge
    } rd_state_t;

    function automatic int unsigned wrap_inc(int unsigned p, int unsigned lim);
        return (p + 1 >= lim) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/rfifo_mem.sv
module rfifo_mem #(
    parameter int DW    = 9,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/rfifo_flags.sv
module rfifo_flags
    import rfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input  fifo_mode_e    mode,
    input  logic [CW-1:0] cnt,
    input  logic          out_valid,
    input  logic          busy,
    output logic          rd_flag_n,
    output logic          wr_flag_n,
    output logic          half_n
);
    logic          full;
    logic          has_data;
    logic [CW-1:0] total;

    assign full     = (cnt == CW'(DEPTH));
    assign has_data = (cnt != '0);
    assign total    = cnt + CW'(out_valid && (mode == MODE_FWFT));

    always_comb begin
        if (mode == MODE_STD) begin
            rd_flag_n = has_data && !busy;
            wr_flag_n = !full;
        end else begin
            rd_flag_n = !out_valid;
            wr_flag_n = full;
        end
        half_n = !(total > CW'(DEPTH / 2));
    end
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
    import rfifo_pkg::*;
#(
    parameter int DW    = 9,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          fall_sel,
    input  logic [DW-1:0] din,
    input  logic          wr_en_n,
    input  logic          rd_en_n,
    input  logic          rewind_n,
    output logic [DW-1:0] dout,
    output logic          rd_flag_n,
    output logic          wr_flag_n,
    output logic          half_n
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 2);

    fifo_mode_e    mode;
    rd_state_t     st;
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic [DW-1:0] mem_q;
    logic          rst_any, can_wr, has_data, rw_req, pop;

    assign rst_any  = mrst || prst;
    assign has_data = (cnt != '0);
    assign can_wr   = !wr_en_n && (cnt != CW'(DEPTH));
    assign rw_req   = !rewind_n && rd_en_n && wr_en_n && !st.busy;

    always_comb begin
        pop = 1'b0;
        if (st.busy)
            pop = (mode == MODE_FWFT) && has_data;
        else if (rw_req)
            pop = 1'b0;
        else if (mode == MODE_STD)
            pop = !rd_en_n && has_data;
        else
            pop = has_data && ((st.out_valid && !rd_en_n) || (st.arm && !st.out_valid));
    end

    rfifo_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (can_wr && !rst_any),
        .waddr (wptr),
        .wdata (din),
        .raddr (rptr),
        .rdata (mem_q)
    );

    rfifo_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
        .mode      (mode),
        .cnt       (cnt),
        .out_valid (st.out_valid),
        .busy      (st.busy),
        .rd_flag_n (rd_flag_n),
        .wr_flag_n (wr_flag_n),
        .half_n    (half_n)
    );

    always_ff @(posedge clk) begin
        if (mrst) mode <= fall_sel ? MODE_FWFT : MODE_STD;
    end

    always_ff @(posedge clk) begin
        if (rst_any) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
            st   <= '0;
            dout <= '0;
        end else begin
            if (can_wr) wptr <= AW'(wrap_inc(32'(wptr), DEPTH));
            if (rw_req) begin
                rptr         <= '0;
                cnt          <= CW'(wptr);
                st.busy      <= 1'b1;
                st.out_valid <= 1'b0;
                st.arm       <= 1'b0;
            end else begin
                if (pop) rptr <= AW'(wrap_inc(32'(rptr), DEPTH));
                cnt     <= cnt + CW'(can_wr) - CW'(pop);
                st.busy <= 1'b0;
                if (mode == MODE_STD) begin
                    if (pop) dout <= mem_q;
                end else begin
                    if (pop) begin
                        dout         <= mem_q;
                        st.out_valid <= 1'b1;
                    end else if (st.out_valid && !rd_en_n && !st.busy) begin
                        st.out_valid <= 1'b0;
                    end
                    st.arm <= !st.out_valid && has_data && !st.busy && !pop;
                end
            end
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst_any)
        cnt <= CW'(DEPTH));

    // R1, R3
    mode_keep_chk: assert property (@(posedge clk) disable iff (mrst)
        prst |=> $stable(mode));

    // R2
    reset_clear_chk: assert property (@(posedge clk) disable iff (prst)
        $fell(mrst) |-> (dout == '0 && half_n));

    // R9
    rewind_ptr_chk: assert property (@(posedge clk) disable iff (rst_any)
        (!rewind_n && rd_en_n && wr_en_n && !st.busy) |=> (rptr == '0 && st.busy));

    // R12
    rewind_ignore_chk: assert property (@(posedge clk) disable iff (rst_any)
        (!rewind_n && (!rd_en_n || !wr_en_n) && !st.busy) |=> !st.busy);

    // R11
    fwft_setup_chk: assert property (@(posedge clk) disable iff (rst_any)
        ($fell(st.busy) && !$past(rst_any) && mode == MODE_FWFT && $past(cnt) != '0)
            |-> st.out_valid);
endmodule

// File: tb/rewind_fifo_test.sv
module rewind_fifo_test;
    localparam int CLK_P = 10;
    localparam int DW    = 9;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          mrst = 1'b1, prst = 1'b0, fall_sel = 1'b0;
    logic [DW-1:0] din = '0;
    logic          wr_en_n = 1'b1, rd_en_n = 1'b1, rewind_n = 1'b1;
    logic [DW-1:0] dout;
    logic          rd_flag_n, wr_flag_n, half_n;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] q[$];
    logic [DW-1:0] saved[$];

    always #(CLK_P / 2) clk = ~clk;

    rewind_fifo #(.DW(DW), .DEPTH(DEPTH)) uut (
        .clk(clk), .mrst(mrst), .prst(prst), .fall_sel(fall_sel),
        .din(din), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .rewind_n(rewind_n),
        .dout(dout), .rd_flag_n(rd_flag_n), .wr_flag_n(wr_flag_n), .half_n(half_n)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    // driver: one write edge; push to scoreboard when it is expected to be accepted
    task automatic drv_wr(input logic [DW-1:0] d, input bit accept);
        din = d; wr_en_n = 1'b0;
        tick();
        wr_en_n = 1'b1;
        if (accept) q.push_back(d);
    endtask

    // monitor, standard mode: read edge then compare against scoreboard head
    task automatic mon_rd_std(input string tag);
        logic [DW-1:0] e;
        rd_en_n = 1'b0;
        tick();
        rd_en_n = 1'b1;
        e = q.pop_front();
        chk_eq(tag, int'(dout), int'(e));
    endtask

    // monitor, fall-through mode: head must already be on dout, then consume it
    task automatic mon_rd_fwft(input string tag);
        logic [DW-1:0] e;
        e = q.pop_front();
        chk_eq(tag, int'(dout), int'(e));
        rd_en_n = 1'b0;
        tick();
        rd_en_n = 1'b1;
    endtask

    task automatic do_mrst(input logic sel);
        mrst = 1'b1; fall_sel = sel;
        tick(); tick();
        mrst = 1'b0; fall_sel = 1'b0;
        q.delete();
    endtask

    task automatic do_prst(input logic sel_noise);
        prst = 1'b1; fall_sel = sel_noise;
        tick();
        prst = 1'b0; fall_sel = 1'b0;
        q.delete();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // ---------------- standard mode ----------------
        do_mrst(1'b0);
        chk_eq("R2 std empty flag after mrst", int'(rd_flag_n), 0);
        chk_eq("R2 std full flag after mrst", int'(wr_flag_n), 1);
        chk_eq("R2 half flag after mrst", int'(half_n), 1);
        chk_eq("R2 dout after mrst", int'(dout), 0);
        chk_eq("R1 std polarity selected", int'(rd_flag_n), 0);

        drv_wr(9'h011, 1); drv_wr(9'h022, 1); drv_wr(9'h033, 1);
        chk_eq("R5 not empty after writes", int'(rd_flag_n), 1);
        for (int i = 0; i < 3; i++) mon_rd_std("R5 std read order");
        chk_eq("R5 empty after drain", int'(rd_flag_n), 0);
        rd_en_n = 1'b0; tick(); rd_en_n = 1'b1;
        chk_eq("R5 read on empty keeps dout", int'(dout), 9'h033);

        for (int i = 0; i < DEPTH; i++) begin
            drv_wr(DW'(i * 3 + 1), 1);
            if (i == DEPTH / 2 - 1) chk_eq("R8 half flag at DEPTH/2", int'(half_n), 1);
            if (i == DEPTH / 2)     chk_eq("R8 half flag above DEPTH/2", int'(half_n), 0);
        end
        chk_eq("R4 full flag at DEPTH", int'(wr_flag_n), 0);
        drv_wr(9'h1ff, 0);
        for (int i = 0; i < DEPTH; i++) mon_rd_std("R4 data after dropped write");
        chk_eq("R4 empty after full drain", int'(rd_flag_n), 0);

        // partial reset keeps standard mode even with fall_sel high
        drv_wr(9'h0aa, 1); drv_wr(9'h0bb, 1);
        mon_rd_std("R5 read before prst");
        do_prst(1'b1);
        chk_eq("R3 dout cleared by prst", int'(dout), 0);
        chk_eq("R3 std empty after prst", int'(rd_flag_n), 0);
        chk_eq("R1 std kept across prst", int'(wr_flag_n), 1);

        // rewind in standard mode
        for (int i = 0; i < 5; i++) drv_wr(DW'(9'h0a0 + i), 1);
        saved = q;
        mon_rd_std("R5 pre-rewind read"); mon_rd_std("R5 pre-rewind read");
        rewind_n = 1'b0; tick(); rewind_n = 1'b1;
        chk_eq("R10 empty low during setup", int'(rd_flag_n), 0);
        tick();
        chk_eq("R10 empty high after setup", int'(rd_flag_n), 1);
        q = saved;
        for (int i = 0; i < 5; i++) mon_rd_std("R9 replay from first location");

        // ignored rewinds
        drv_wr(9'h0c0, 1); drv_wr(9'h0c1, 1);
        mon_rd_std("R12 read before ignored rewind");
        din = 9'h0c2; wr_en_n = 1'b0; rewind_n = 1'b0;
        tick();
        wr_en_n = 1'b1; rewind_n = 1'b1; q.push_back(9'h0c2);
        chk_eq("R12 no setup with write low", int'(rd_flag_n), 1);
        mon_rd_std("R12 pointer kept with write"); mon_rd_std("R12 pointer kept with write");
        drv_wr(9'h0c3, 1);
        rd_en_n = 1'b0; rewind_n = 1'b0;
        tick();
        rd_en_n = 1'b1; rewind_n = 1'b1;
        chk_eq("R12 read proceeds with rewind low", int'(dout), int'(q.pop_front()));

        // ---------------- fall-through mode ----------------
        do_mrst(1'b1);
        chk_eq("R2 fwft ready flag after mrst", int'(rd_flag_n), 1);
        chk_eq("R2 fwft input ready after mrst", int'(wr_flag_n), 0);
        chk_eq("R2 fwft half after mrst", int'(half_n), 1);
        chk_eq("R2 fwft dout after mrst", int'(dout), 0);

        drv_wr(9'h155, 1);
        chk_eq("R6 not ready one edge after write", int'(rd_flag_n), 1);
        tick();
        chk_eq("R6 not ready two edges after write", int'(rd_flag_n), 1);
        tick();
        chk_eq("R6 ready after second following edge", int'(rd_flag_n), 0);
        drv_wr(9'h156, 1); drv_wr(9'h157, 1);
        for (int i = 0; i < 3; i++) mon_rd_fwft("R6 fall-through read order");
        chk_eq("R6 not ready after last read", int'(rd_flag_n), 1);

        for (int i = 0; i < DEPTH + 1; i++) begin
            drv_wr(DW'(9'h100 + i), 1);
            if (i == DEPTH - 1) chk_eq("R7 room at DEPTH", int'(wr_flag_n), 0);
        end
        chk_eq("R7 no room at DEPTH+1", int'(wr_flag_n), 1);
        chk_eq("R8 fwft half at DEPTH+1", int'(half_n), 0);
        drv_wr(9'h0ee, 0);
        for (int i = 0; i < DEPTH + 1; i++) mon_rd_fwft("R7 DEPTH+1 words kept");
        chk_eq("R7 not ready after drain", int'(rd_flag_n), 1);

        // partial reset keeps fall-through mode even with fall_sel low
        do_prst(1'b0);
        chk_eq("R3 fwft ready flag after prst", int'(rd_flag_n), 1);
        chk_eq("R1 fwft kept across prst", int'(wr_flag_n), 0);

        for (int i = 0; i < 4; i++) drv_wr(DW'(9'h0d0 + i), 1);
        saved = q;
        tick(); tick();
        mon_rd_fwft("R6 head before rewind");
        rewind_n = 1'b0; tick(); rewind_n = 1'b1;
        chk_eq("R11 not ready during setup", int'(rd_flag_n), 1);
        tick();
        chk_eq("R11 ready after setup", int'(rd_flag_n), 0);
        q = saved;
        for (int i = 0; i < 4; i++) mon_rd_fwft("R11 first word without read");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule